// File: doc/BRIEF.md
# Free-Running Timer with Overflow Flag

This block is a free-running up-counter whose width is a parameter, by default 16 bits. A fixed prescaler divides the bus clock by four in front of it. Software reaches it through a small 8-bit register window. The window has a control register with an overflow interrupt enable, a status register with an overflow flag, and a read-only pair of bytes that expose the counter. The counter starts three counts below its wrap point. With the default width, its sequence repeats every 262,144 bus clocks.

A rollover from the all-ones value to zero sets the overflow flag. The only way to clear the flag is a two-step read handshake. Software first reads status while the flag is set, and a later read of the counter low byte then clears it. An overflow that arrives during that handshake cancels it, so no overflow is lost. Reading the high byte captures the low byte at the same instant, which makes a high-then-low read pair a coherent 16-bit sample. The interrupt request is a registered output that is high while both the flag and the enable are set.

Top module: `frc_timer`

## Requirements
- R1: Synchronous active-high reset does all of the following: loads the counter with all-ones minus three (0xFFFC at 16 bits), zeroes the prescaler, clears the enable, the overflow flag and the clear handshake, and drives bus_rdata and irq to 0.
- R2: The counter adds one modulo 2^CNT_W on every fourth clock edge after reset release, with the first increment on the fourth edge, so the full sequence repeats every 4*2^CNT_W clocks.
- R3: A read of address 2 returns the counter's upper byte, with bits above CNT_W reading 0, and captures the current low byte. The next read of address 3 returns that captured byte.
- R4: A read of address 3 with no capture pending returns the live low byte of the counter.
- R5: Status bit 7 at address 1 is the overflow flag. It rises on the clock edge where the counter steps from all-ones to zero.
- R6: The flag is cleared by an address-3 read only when a status read earlier saw the flag set. An address-3 read on its own, or one after a status read that saw the flag clear, leaves the flag set.
- R7: An overflow after the arming status read, or in the same cycle as the clearing address-3 read, leaves the flag set and cancels the handshake.
- R8: Address 0 bit 0 is the interrupt enable, which can be read and written. The other control bits read 0. irq is high exactly when the flag and the enable are both set, and it changes on the same edge as they do.
- R9: Writes to addresses 1, 2 and 3 change neither the counter, nor the flag, nor the clear handshake.
- R10: Read data is registered. It appears on bus_rdata one edge after the read is presented and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 count high, 3 count low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
The counter rollover, which sets the flag, and the address-3 read, which clears it, can land on the same clock edge. The bench arms the handshake with a status read. It then times a low-byte read to hit the exact edge where the counter wraps, using an arithmetic model of the edge count since reset. It judges the result by reading status afterwards and expects the flag still set. A separate case lets a whole counter period pass between arming and the low read, and the flag must again survive.

// File: rtl/frc_timer_pkg.sv
package frc_timer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STAT   = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_CNT_LO = 2'd3
  } frc_reg_e;

  localparam int BUS_W        = 8;
  localparam int CTRL_EN_BIT  = 0;
  localparam int STAT_OVF_BIT = 7;
endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + DIV_LOG2'(1);
  end

  // one pulse per 2**DIV_LOG2 clocks, on the last phase
  assign tick = &div_q;
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= RST_VAL;
    else if (tick) cnt <= cnt + CNT_W'(1);
  end

  // the step that takes all-ones to zero
  assign wrap = tick & (&cnt);
endmodule

// File: rtl/frc_ovf_flag.sv
module frc_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic stat_rd,
  input  logic lo_rd,
  output logic flag,
  output logic flag_nxt,
  output logic armed
);
  logic armed_nxt;

  always_comb begin
    flag_nxt  = flag;
    armed_nxt = armed;
    if (wrap) begin
      // a new overflow beats any clear and cancels the handshake
      flag_nxt  = 1'b1;
      armed_nxt = 1'b0;
    end else if (lo_rd && armed) begin
      flag_nxt  = 1'b0;
      armed_nxt = 1'b0;
    end else if (stat_rd && flag) begin
      armed_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_nxt;
      armed <= armed_nxt;
    end
  end
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DIV_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);
  // CNT_W must lie in 9..16 so the counter spans both bytes
  localparam logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}} - CNT_W'(3);
  localparam int HI_W = CNT_W - BUS_W;

  frc_reg_e         reg_sel;
  logic             rd_en, wr_en;
  logic             stat_rd, hi_rd, lo_rd, ctrl_wr;
  logic             pre_tick, cnt_wrap;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_flag, ovf_flag_nxt, clr_armed;
  logic             ctrl_en, ctrl_en_nxt;
  logic [BUS_W-1:0] cnt_hi, lo_buf, rd_mux;
  logic             lo_buf_vld;
  logic             unused_bits;

  assign reg_sel = frc_reg_e'(bus_addr);
  assign rd_en   = bus_sel & ~bus_wr;
  assign wr_en   = bus_sel &  bus_wr;
  assign stat_rd = rd_en && (reg_sel == REG_STAT);
  assign hi_rd   = rd_en && (reg_sel == REG_CNT_HI);
  assign lo_rd   = rd_en && (reg_sel == REG_CNT_LO);
  assign ctrl_wr = wr_en && (reg_sel == REG_CTRL);

  frc_prescale #(.DIV_LOG2(DIV_LOG2)) u_prescale (
    .clk  (clk),
    .rst  (rst),
    .tick (pre_tick)
  );

  frc_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_counter (
    .clk  (clk),
    .rst  (rst),
    .tick (pre_tick),
    .cnt  (cnt_q),
    .wrap (cnt_wrap)
  );

  frc_ovf_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .wrap     (cnt_wrap),
    .stat_rd  (stat_rd),
    .lo_rd    (lo_rd),
    .flag     (ovf_flag),
    .flag_nxt (ovf_flag_nxt),
    .armed    (clr_armed)
  );

  // upper byte, zero-filled when the counter is narrower than 16 bits
  generate
    if (HI_W == BUS_W) begin : g_full_hi
      assign cnt_hi = cnt_q[CNT_W-1:BUS_W];
    end else begin : g_pad_hi
      assign cnt_hi = {{(BUS_W-HI_W){1'b0}}, cnt_q[CNT_W-1:BUS_W]};
    end
  endgenerate

  assign ctrl_en_nxt = ctrl_wr ? bus_wdata[CTRL_EN_BIT] : ctrl_en;

  always_ff @(posedge clk) begin
    if (rst) ctrl_en <= 1'b0;
    else     ctrl_en <= ctrl_en_nxt;
  end

  // low-byte capture for coherent high/low reads
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_buf     <= '0;
      lo_buf_vld <= 1'b0;
    end else if (hi_rd) begin
      lo_buf     <= cnt_q[BUS_W-1:0];
      lo_buf_vld <= 1'b1;
    end else if (lo_rd) begin
      lo_buf_vld <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel)
      REG_CTRL:   rd_mux[CTRL_EN_BIT]  = ctrl_en;
      REG_STAT:   rd_mux[STAT_OVF_BIT] = ovf_flag;
      REG_CNT_HI: rd_mux = cnt_hi;
      REG_CNT_LO: rd_mux = lo_buf_vld ? lo_buf : cnt_q[BUS_W-1:0];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd_en) bus_rdata <= rd_mux;
      irq <= ovf_flag_nxt & ctrl_en_nxt;
    end
  end

  assign unused_bits = ^{bus_wdata, clr_armed};
endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk
  import frc_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DIV_LOG2 = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             armed,
  input logic             en,
  input logic             irq
);
  localparam logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}} - CNT_W'(3);

  logic                lo_rd, cnt_wr, ro_wr;
  logic [DIV_LOG2-1:0] gap;

  assign lo_rd  = bus_sel && !bus_wr && (bus_addr == REG_CNT_LO);
  assign cnt_wr = bus_sel && bus_wr && (bus_addr == REG_CNT_HI || bus_addr == REG_CNT_LO);
  assign ro_wr  = bus_sel && bus_wr && (bus_addr != REG_CTRL);

  // clocks since the last prescaler pulse
  always_ff @(posedge clk) begin
    if (rst || tick) gap <= '0;
    else             gap <= gap + DIV_LOG2'(1);
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == RST_VAL) && !en && !flag && !armed && !irq);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  a_r2_prescale_period: assert property (@(posedge clk) disable iff (rst)
    tick |-> gap == {DIV_LOG2{1'b1}});

  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag && !armed);

  a_r6_clear_needs_handshake: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(lo_rd) && $past(armed));

  a_r6_arm_needs_flag: assert property (@(posedge clk) disable iff (rst)
    armed |-> flag);

  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && en));

  a_r9_count_read_only: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt == CNT_W'($past(cnt) + CNT_W'($past(tick))));

  a_r9_flag_write_ignored: assert property (@(posedge clk) disable iff (rst)
    ro_wr && !wrap |=> $stable(flag) && $stable(armed));
endmodule

bind frc_timer frc_timer_chk #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_frc_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .tick     (pre_tick),
  .wrap     (cnt_wrap),
  .cnt      (cnt_q),
  .flag     (ovf_flag),
  .armed    (clr_armed),
  .en       (ctrl_en),
  .irq      (irq)
);

// File: tb/test_frc_timer.sv
`timescale 1ns/1ps
module test_frc_timer;
  localparam int W   = 10;
  localparam int RST = (1 << W) - 4;
  localparam int PER = 4 << W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;
  int         edges = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  frc_timer #(.CNT_W(W), .DIV_LOG2(2)) i_frc_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // counter value after n edges since reset release
  function automatic int cnt_at(input int n);
    return (RST + n / 4) % (1 << W);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output int n);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata; n = edges;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // stop at a negedge where edges has reached t
  task automatic idle_until(input int t);
    while (edges < t) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, dh;
    int n, nh, r;
    do_reset();
    #1;
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 rdata after reset", int'(bus_rdata), 0);
    rd(2'd0, d, n); chk("R1 ctrl reset", d, 0);
    rd(2'd1, d, n); chk("R1 status reset", d, 0);
    rd(2'd3, d, n); chk("R1 R4 live low from reset", d, cnt_at(n - 1) & 8'hFF);
    rd(2'd2, d, n); chk("R1 high from reset", d, (cnt_at(n - 1) >> 8) & 8'hFF);

    // R2 R3 R4: sweep across more than one full period
    for (int k = 0; k < 1400; k++) begin
      rd(2'd2, dh, nh);
      chk("R2 R3 high byte", dh, (cnt_at(nh - 1) >> 8) & 8'hFF);
      for (int j = 0; j < k % 4; j++) @(negedge clk);
      rd(2'd3, d, n);
      chk("R3 captured low byte", d, cnt_at(nh - 1) & 8'hFF);
      if (k % 2 == 1) begin
        rd(2'd3, d, n);
        chk("R4 live low byte", d, cnt_at(n - 1) & 8'hFF);
      end
    end
    chk("R2 sweep spanned a period", int'(edges > PER), 1);

    // R1: enable is cleared by a second reset
    wr(2'd0, 8'h01);
    do_reset();
    rd(2'd0, d, n); chk("R1 ctrl cleared by reset", d, 0);

    // R5: flag rises on edge 16 (first wrap)
    idle_until(13);
    rd(2'd1, d, n); chk("R5 status before wrap", d, 0);
    chk("R5 read edge", n, 15);
    rd(2'd1, d, n); chk("R5 status at wrap edge", d, 0);
    // R6: low read alone does not clear
    rd(2'd3, d, n);
    rd(2'd1, d, n); chk("R5 R6 flag set, low read alone kept it", d, 8'h80);
    rd(2'd2, d, n);
    rd(2'd3, d, n);
    rd(2'd1, d, n); chk("R6 handshake clears flag", d, 0);
    chk("R8 irq low with flag clear", int'(irq), 0);

    // R6: status read that saw the flag clear does not arm
    r = 16 + PER;
    idle_until(r + 2);
    rd(2'd3, d, n);
    rd(2'd1, d, n); chk("R6 unarmed low read keeps flag", d, 8'h80);

    // R7: overflow between arming and low read
    r = 16 + 2 * PER;
    idle_until(r + 2);
    rd(2'd3, d, n);
    rd(2'd1, d, n); chk("R7 overflow after arm keeps flag", d, 8'h80);

    // R7: low read on the very wrap edge
    r = 16 + 3 * PER;
    idle_until(r - 2);
    rd(2'd3, d, n);
    chk("R7 low read hit wrap edge", n, r);
    rd(2'd1, d, n); chk("R7 same-cycle overflow keeps flag", d, 8'h80);

    // R8: enable and irq
    chk("R8 irq low while disabled", int'(irq), 0);
    wr(2'd0, 8'h01);
    chk("R8 irq high with flag and enable", int'(irq), 1);
    rd(2'd0, d, n); chk("R8 enable reads back", d, 8'h01);
    wr(2'd0, 8'hFF);
    rd(2'd0, d, n); chk("R8 spare ctrl bits read 0", d, 8'h01);

    // R9: writes to status and counter are ignored
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h55);
    rd(2'd1, d, n); chk("R9 status write ignored", d, 8'h80);
    rd(2'd2, dh, nh); chk("R9 high unaffected by write", dh, (cnt_at(nh - 1) >> 8) & 8'hFF);
    rd(2'd3, d, n); chk("R9 low unaffected by write", d, cnt_at(nh - 1) & 8'hFF);
    chk("R6 R8 clear drops irq", int'(irq), 0);
    rd(2'd1, d, n); chk("R6 flag clear after handshake", d, 0);

    // R10: read data holds while idle
    rd(2'd0, d, n);
    repeat (3) @(negedge clk);
    chk("R10 rdata held", int'(bus_rdata), 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule